// File: doc/BRIEF.md
# Multiply and Multiply-Accumulate Register Peripheral

This block is a multiplier that a small processor reaches through a plain synchronous register port with word addresses and 16-bit data. Software writes a first operand to one of several addresses, and the address it picks sets the operation. The choices are an unsigned product, a two's-complement product, or an unsigned product added into the running result. Writing the second operand fires the operation. The 32-bit result is registered on that same clock edge, so the next bus access can already read it and no busy flag is needed. The first operand and the chosen operation stay in place, so writing the second operand again repeats the operation on a new value. Both result words can also be written by software, which lets it preload or clear a running sum.

A separate 32x32 bank follows the same pattern. The first operand is written as a low and a high word, through either an unsigned or a signed address pair. The second operand is written as a low and a high word, and writing its high word starts the product. The 64-bit product comes back in four result words. The two lowest of these also form the truncated 32-bit product. Reads of any unused address return zero, and writes to them do nothing.

Top module: `mpymac_periph`

## Requirements
- R1: After reset, every operand and result register reads as 0x0000.
- R2: Write A to address 0x00 (unsigned mode), then B to 0x03. On the next access, 0x04 holds bits 15:0 and 0x05 holds bits 31:16 of the unsigned product A*B.
- R3: Write A to 0x01 (signed mode), then B to 0x03. On the next access, 0x04/0x05 hold the two's-complement product of A and B.
- R4: Write A to 0x02 (accumulate mode), then B to 0x03. The pair {0x05,0x04} becomes its previous value plus the unsigned product A*B, wrapping modulo 2^32.
- R5: Software writes to 0x04 and 0x05 replace the low and high result words. A following accumulate adds to the written value.
- R6: The operand-1 value and its mode are held after a trigger. Each further write to 0x03, including writes on consecutive cycles, repeats the operation with the held operand 1.
- R7: In 32-bit mode the four result words 0x10 (least significant) to 0x13 change only when 0x0D (operand-2 high word) is written. A write to 0x0C (operand-2 low word) leaves them unchanged.
- R8: Write operand 1 low/high through 0x08/0x09 (unsigned) or 0x0A/0x0B (signed), and operand 2 low through 0x0C. Writing the operand-2 high word to 0x0D then puts the 64-bit product in 0x10..0x13. The signedness comes from whichever 32-bit operand-1 address was written last.
- R9: Operand registers read back their last written value. Reading any of 0x00/0x01/0x02 returns operand 1, and 0x03 returns operand 2. 0x08/0x0A return the 32-bit operand-1 low word and 0x09/0x0B its high word. 0x0C/0x0D return the operand-2 words.
- R10: Reads of unmapped addresses return 0x0000. Writes to unmapped addresses, and writes to the read-only words 0x10..0x13, change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Write strobe for the current address |
| addr | input | 5 | Word address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr`, combinational from the registers |

## Verification
The bench builds the block with its default 16-bit word, so the 16x16 path and the 32x32 path, with its four-word product, are both at their full width. This puts the edge operand 0x8000 within reach in both signed and unsigned form, along with 0x80000000 squared and 0xFFFFFFFF in both sign modes. It also covers accumulate wrap past 0xFFFFFFFF and repeated triggers on consecutive cycles. A reference model in the bench tracks every write and predicts each read, and it is driven with both directed and random operand sequences.

// File: rtl/mpymac_pkg.sv
package mpymac_pkg;
  localparam int ADDR_W = 5;

  localparam logic [ADDR_W-1:0] A_OPA_U   = 5'h00;
  localparam logic [ADDR_W-1:0] A_OPA_S   = 5'h01;
  localparam logic [ADDR_W-1:0] A_OPA_ACC = 5'h02;
  localparam logic [ADDR_W-1:0] A_OPB     = 5'h03;
  localparam logic [ADDR_W-1:0] A_RLO     = 5'h04;
  localparam logic [ADDR_W-1:0] A_RHI     = 5'h05;
  localparam logic [ADDR_W-1:0] A_XA_LO_U = 5'h08;
  localparam logic [ADDR_W-1:0] A_XA_HI_U = 5'h09;
  localparam logic [ADDR_W-1:0] A_XA_LO_S = 5'h0A;
  localparam logic [ADDR_W-1:0] A_XA_HI_S = 5'h0B;
  localparam logic [ADDR_W-1:0] A_XB_LO   = 5'h0C;
  localparam logic [ADDR_W-1:0] A_XB_HI   = 5'h0D;
  localparam logic [ADDR_W-1:0] A_XR0     = 5'h10;
  localparam logic [ADDR_W-1:0] A_XR1     = 5'h11;
  localparam logic [ADDR_W-1:0] A_XR2     = 5'h12;
  localparam logic [ADDR_W-1:0] A_XR3     = 5'h13;

  typedef enum logic [1:0] {MD_UNS, MD_SGN, MD_ACC} mode16_e;

  typedef enum logic [3:0] {
    RS_NONE, RS_OPA, RS_OPB, RS_RLO, RS_RHI, RS_XA_LO, RS_XA_HI,
    RS_XB_LO, RS_XB_HI, RS_XR0, RS_XR1, RS_XR2, RS_XR3
  } rsel_e;

  typedef struct packed {
    logic opa_u;
    logic opa_s;
    logic opa_acc;
    logic opb;
    logic rlo;
    logic rhi;
    logic xa_lo;
    logic xa_hi;
    logic xa_sgn;
    logic xb_lo;
    logic xb_hi;
  } wr_strb_t;
endpackage

// File: rtl/mpymac_decode.sv
module mpymac_decode
  import mpymac_pkg::*;
(
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  output wr_strb_t          strb,
  output rsel_e             rsel
);
  always_comb begin
    strb = '0;
    rsel = RS_NONE;
    case (addr)
      A_OPA_U:   begin strb.opa_u   = wr_en; rsel = RS_OPA; end
      A_OPA_S:   begin strb.opa_s   = wr_en; rsel = RS_OPA; end
      A_OPA_ACC: begin strb.opa_acc = wr_en; rsel = RS_OPA; end
      A_OPB:     begin strb.opb     = wr_en; rsel = RS_OPB; end
      A_RLO:     begin strb.rlo     = wr_en; rsel = RS_RLO; end
      A_RHI:     begin strb.rhi     = wr_en; rsel = RS_RHI; end
      A_XA_LO_U: begin strb.xa_lo   = wr_en; rsel = RS_XA_LO; end
      A_XA_HI_U: begin strb.xa_hi   = wr_en; rsel = RS_XA_HI; end
      A_XA_LO_S: begin strb.xa_lo   = wr_en; strb.xa_sgn = 1'b1; rsel = RS_XA_LO; end
      A_XA_HI_S: begin strb.xa_hi   = wr_en; strb.xa_sgn = 1'b1; rsel = RS_XA_HI; end
      A_XB_LO:   begin strb.xb_lo   = wr_en; rsel = RS_XB_LO; end
      A_XB_HI:   begin strb.xb_hi   = wr_en; rsel = RS_XB_HI; end
      A_XR0:     rsel = RS_XR0;
      A_XR1:     rsel = RS_XR1;
      A_XR2:     rsel = RS_XR2;
      A_XR3:     rsel = RS_XR3;
      default:   rsel = RS_NONE;
    endcase
  end
endmodule

// File: rtl/mpymac_mult.sv
module mpymac_mult #(
  parameter int N = 16
) (
  input  logic [N-1:0]   a,
  input  logic [N-1:0]   b,
  input  logic           sgn,
  output logic [2*N-1:0] p
);
  localparam int PW = 2*N + 2;

  logic [N:0]          ax;
  logic [N:0]          bx;
  logic signed [PW-1:0] full;

  always_comb begin
    ax   = {sgn & a[N-1], a};
    bx   = {sgn & b[N-1], b};
    full = $signed(ax) * $signed(bx);
    p    = full[2*N-1:0];
  end
endmodule

// File: rtl/mpymac_periph.sv
module mpymac_periph
  import mpymac_pkg::*;
#(
  parameter int W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [W-1:0]      wdata,
  output logic [W-1:0]      rdata
);
  localparam int W2 = 2*W;
  localparam int W4 = 4*W;

  // reset: asserted asynchronously, released after two clock edges
  logic [1:0] rs_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sync_n = rs_q[1];

  wr_strb_t strb;
  rsel_e    rsel;

  mpymac_decode u_decode (
    .wr_en (wr_en),
    .addr  (addr),
    .strb  (strb),
    .rsel  (rsel)
  );

  // state
  logic [W-1:0]  opa_q,  opa_d;
  mode16_e       mode_q, mode_d;
  logic [W-1:0]  opb_q,  opb_d;
  logic [W2-1:0] res_q,  res_d;
  logic [W2-1:0] xa_q,   xa_d;
  logic          xsgn_q, xsgn_d;
  logic [W2-1:0] xb_q,   xb_d;
  logic [W4-1:0] xres_q, xres_d;

  logic opa_en, opb_en, res_en, xa_en, xb_en, xres_en;

  // datapath
  logic [W2-1:0] prod16;
  logic [W4-1:0] prod32;
  logic [W2-1:0] xb_full;

  assign xb_full = {wdata, xb_q[W-1:0]};

  mpymac_mult #(.N(W)) u_mul16 (
    .a   (opa_q),
    .b   (wdata),
    .sgn (mode_q == MD_SGN),
    .p   (prod16)
  );

  mpymac_mult #(.N(W2)) u_mul32 (
    .a   (xa_q),
    .b   (xb_full),
    .sgn (xsgn_q),
    .p   (prod32)
  );

  // next state and enables
  always_comb begin
    opa_en  = strb.opa_u | strb.opa_s | strb.opa_acc;
    opb_en  = strb.opb;
    res_en  = strb.opb | strb.rlo | strb.rhi;
    xa_en   = strb.xa_lo | strb.xa_hi;
    xb_en   = strb.xb_lo | strb.xb_hi;
    xres_en = strb.xb_hi;

    opa_d  = wdata;
    mode_d = strb.opa_s   ? MD_SGN :
             strb.opa_acc ? MD_ACC : MD_UNS;
    opb_d  = wdata;

    res_d = res_q;
    if (strb.rlo) res_d[W-1:0]  = wdata;
    if (strb.rhi) res_d[W2-1:W] = wdata;
    if (strb.opb) res_d = (mode_q == MD_ACC) ? (res_q + prod16) : prod16;

    xa_d   = xa_q;
    if (strb.xa_lo) xa_d[W-1:0]  = wdata;
    if (strb.xa_hi) xa_d[W2-1:W] = wdata;
    xsgn_d = strb.xa_sgn;

    xb_d = xb_q;
    if (strb.xb_lo) xb_d[W-1:0]  = wdata;
    if (strb.xb_hi) xb_d[W2-1:W] = wdata;

    xres_d = prod32;
  end

  // registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      opa_q  <= '0;
      mode_q <= MD_UNS;
      opb_q  <= '0;
      res_q  <= '0;
      xa_q   <= '0;
      xsgn_q <= 1'b0;
      xb_q   <= '0;
      xres_q <= '0;
    end else begin
      if (opa_en) begin
        opa_q  <= opa_d;
        mode_q <= mode_d;
      end
      if (opb_en) opb_q <= opb_d;
      if (res_en) res_q <= res_d;
      if (xa_en) begin
        xa_q   <= xa_d;
        xsgn_q <= xsgn_d;
      end
      if (xb_en)   xb_q   <= xb_d;
      if (xres_en) xres_q <= xres_d;
    end
  end

  // read-back
  always_comb begin
    case (rsel)
      RS_OPA:   rdata = opa_q;
      RS_OPB:   rdata = opb_q;
      RS_RLO:   rdata = res_q[W-1:0];
      RS_RHI:   rdata = res_q[W2-1:W];
      RS_XA_LO: rdata = xa_q[W-1:0];
      RS_XA_HI: rdata = xa_q[W2-1:W];
      RS_XB_LO: rdata = xb_q[W-1:0];
      RS_XB_HI: rdata = xb_q[W2-1:W];
      RS_XR0:   rdata = xres_q[W-1:0];
      RS_XR1:   rdata = xres_q[2*W-1:W];
      RS_XR2:   rdata = xres_q[3*W-1:2*W];
      RS_XR3:   rdata = xres_q[4*W-1:3*W];
      default:  rdata = '0;
    endcase
  end
endmodule

// File: rtl/mpymac_periph_chk.sv
module mpymac_periph_chk
  import mpymac_pkg::*;
#(
  parameter int W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [W-1:0]      wdata,
  input logic [W-1:0]      rdata,
  input mode16_e           mode,
  input logic [W-1:0]      opa,
  input logic [2*W-1:0]    res,
  input logic [2*W-1:0]    xa,
  input logic              xsgn,
  input logic [W-1:0]      xb_lo,
  input logic [4*W-1:0]    xres
);
  logic [2*W-1:0] ua, ub, sa, sb, u16, s16;
  logic [4*W-1:0] ea, eb, x64;
  logic [2*W-1:0] bfull;
  logic           mapped;
  logic           trig16, trig32;

  always_comb begin
    ua    = {{W{1'b0}}, opa};
    ub    = {{W{1'b0}}, wdata};
    sa    = {{W{opa[W-1]}}, opa};
    sb    = {{W{wdata[W-1]}}, wdata};
    u16   = ua * ub;
    s16   = sa * sb;
    bfull = {wdata, xb_lo};
    ea    = xsgn ? {{2*W{xa[2*W-1]}}, xa}       : {{2*W{1'b0}}, xa};
    eb    = xsgn ? {{2*W{bfull[2*W-1]}}, bfull} : {{2*W{1'b0}}, bfull};
    x64   = ea * eb;
    trig16 = wr_en && (addr == A_OPB);
    trig32 = wr_en && (addr == A_XB_HI);
    mapped = (addr <= A_RHI) || ((addr >= A_XA_LO_U) && (addr <= A_XB_HI)) ||
             ((addr >= A_XR0) && (addr <= A_XR3));
  end

  p_umul_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (trig16 && mode == MD_UNS) |=> res == $past(u16));

  p_smul_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (trig16 && mode == MD_SGN) |=> res == $past(s16));

  p_acc_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (trig16 && mode == MD_ACC) |=> res == $past(res) + $past(u16));

  p_xres_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !trig32 |=> $stable(xres));

  p_xmul_r8: assert property (@(posedge clk) disable iff (!rst_n)
    trig32 |=> xres == $past(x64));

  p_unmapped_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !mapped |-> rdata == '0);
endmodule

bind mpymac_periph mpymac_periph_chk #(.W(W)) u_chk (
  .clk   (clk),
  .rst_n (rst_sync_n),
  .wr_en (wr_en),
  .addr  (addr),
  .wdata (wdata),
  .rdata (rdata),
  .mode  (mode_q),
  .opa   (opa_q),
  .res   (res_q),
  .xa    (xa_q),
  .xsgn  (xsgn_q),
  .xb_lo (xb_q[W-1:0]),
  .xres  (xres_q)
);

// File: tb/mpymac_periph_bench.sv
module mpymac_periph_bench;
  import mpymac_pkg::*;

  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic [4:0]  addr;
  logic [15:0] wdata;
  logic [15:0] rdata;

  mpymac_periph u_mpymac_periph (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (wr_en),
    .addr  (addr),
    .wdata (wdata),
    .rdata (rdata)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  // reference model state
  logic [15:0] m_opa, m_opb;
  int          m_mode;
  logic [31:0] m_res, m_xa, m_xb;
  logic        m_xs;
  logic [63:0] m_xr;

  typedef struct {
    logic [15:0] exp;
    logic [4:0]  a;
    string       tag;
  } item_t;
  item_t sb[$];
  event  chk_ev;

  function automatic logic [31:0] ref16(logic [15:0] a, logic [15:0] b, bit s);
    logic [31:0] ea, eb;
    ea = s ? {{16{a[15]}}, a} : {16'h0, a};
    eb = s ? {{16{b[15]}}, b} : {16'h0, b};
    return ea * eb;
  endfunction

  function automatic logic [63:0] ref32(logic [31:0] a, logic [31:0] b, bit s);
    logic [63:0] ea, eb;
    ea = s ? {{32{a[31]}}, a} : {32'h0, a};
    eb = s ? {{32{b[31]}}, b} : {32'h0, b};
    return ea * eb;
  endfunction

  function automatic logic [15:0] model_rd(logic [4:0] a);
    case (a)
      5'h00, 5'h01, 5'h02: return m_opa;
      5'h03: return m_opb;
      5'h04: return m_res[15:0];
      5'h05: return m_res[31:16];
      5'h08, 5'h0A: return m_xa[15:0];
      5'h09, 5'h0B: return m_xa[31:16];
      5'h0C: return m_xb[15:0];
      5'h0D: return m_xb[31:16];
      5'h10: return m_xr[15:0];
      5'h11: return m_xr[31:16];
      5'h12: return m_xr[47:32];
      5'h13: return m_xr[63:48];
      default: return 16'h0;
    endcase
  endfunction

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    case (a)
      5'h00: begin m_opa = d; m_mode = 0; end
      5'h01: begin m_opa = d; m_mode = 1; end
      5'h02: begin m_opa = d; m_mode = 2; end
      5'h03: begin
        m_opb = d;
        if (m_mode == 2) m_res = m_res + ref16(m_opa, d, 1'b0);
        else             m_res = ref16(m_opa, d, m_mode == 1);
      end
      5'h04: m_res[15:0]  = d;
      5'h05: m_res[31:16] = d;
      5'h08: begin m_xa[15:0]  = d; m_xs = 1'b0; end
      5'h09: begin m_xa[31:16] = d; m_xs = 1'b0; end
      5'h0A: begin m_xa[15:0]  = d; m_xs = 1'b1; end
      5'h0B: begin m_xa[31:16] = d; m_xs = 1'b1; end
      5'h0C: m_xb[15:0] = d;
      5'h0D: begin m_xb[31:16] = d; m_xr = ref32(m_xa, m_xb, m_xs); end
      default: ;
    endcase
  endtask

  // driver: one read access, expected value pushed to the scoreboard
  task automatic chk(input logic [4:0] a, input string tag);
    item_t it;
    @(negedge clk);
    wr_en = 1'b0; addr = a; wdata = 16'h0;
    it.exp = model_rd(a); it.a = a; it.tag = tag;
    sb.push_back(it);
    #2;
    ->chk_ev;
  endtask

  // monitor: compares the design output against the scoreboard head
  always @(chk_ev) begin
    item_t it;
    while (sb.size() > 0) begin
      it = sb.pop_front();
      n_chk++;
      if (rdata !== it.exp) begin
        n_fail++;
        $display("FAIL %s addr=0x%02h actual=0x%04h expected=0x%04h",
                 it.tag, it.a, rdata, it.exp);
      end
    end
  end

  function automatic logic [15:0] rnd16();
    case ($urandom % 5)
      0: return 16'h8000;
      1: return 16'hFFFF;
      2: return 16'h0000;
      default: return 16'($urandom);
    endcase
  endfunction

  initial begin
    #(8 * 190000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog (all requirements) actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    m_opa = 0; m_opb = 0; m_mode = 0; m_res = 0;
    m_xa = 0; m_xb = 0; m_xs = 0; m_xr = 0;
    rst_n = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset state
    chk(5'h00, "R1"); chk(5'h03, "R1"); chk(5'h04, "R1"); chk(5'h05, "R1");
    chk(5'h09, "R1"); chk(5'h0D, "R1"); chk(5'h10, "R1"); chk(5'h13, "R1");

    // R2: unsigned 16x16
    wr(5'h00, 16'hFFFF); wr(5'h03, 16'hFFFF);
    chk(5'h04, "R2"); chk(5'h05, "R2");
    wr(5'h00, 16'h8000); wr(5'h03, 16'h8000);
    chk(5'h04, "R2"); chk(5'h05, "R2");

    // R3: signed 16x16
    wr(5'h01, 16'h8000); wr(5'h03, 16'h8000);
    chk(5'h04, "R3"); chk(5'h05, "R3");
    wr(5'h01, 16'hFFFF); wr(5'h03, 16'h0002);
    chk(5'h04, "R3"); chk(5'h05, "R3");
    wr(5'h01, 16'h8000); wr(5'h03, 16'h7FFF);
    chk(5'h05, "R3");

    // R5 + R4: preload then accumulate, with wrap
    wr(5'h04, 16'hFFFF); wr(5'h05, 16'hFFFF);
    chk(5'h04, "R5"); chk(5'h05, "R5");
    wr(5'h02, 16'h0001); wr(5'h03, 16'h0001);
    chk(5'h04, "R4_wrap"); chk(5'h05, "R4_wrap");
    wr(5'h04, 16'h1234); wr(5'h05, 16'h0000);
    wr(5'h02, 16'h8000); wr(5'h03, 16'h8000);
    chk(5'h04, "R4"); chk(5'h05, "R4");

    // R6: held operand, back-to-back triggers
    wr(5'h03, 16'h0003); wr(5'h03, 16'hFFFF);
    chk(5'h04, "R6"); chk(5'h05, "R6");
    wr(5'h01, 16'hFFFE); wr(5'h03, 16'h0005); wr(5'h03, 16'h0007);
    chk(5'h04, "R6"); chk(5'h05, "R6"); chk(5'h00, "R6");

    // R8: 32x32 signed and unsigned corners
    wr(5'h0A, 16'h0000); wr(5'h0B, 16'h8000);
    wr(5'h0C, 16'h0000); wr(5'h0D, 16'h8000);
    chk(5'h10, "R8"); chk(5'h11, "R8"); chk(5'h12, "R8"); chk(5'h13, "R8");
    wr(5'h08, 16'hFFFF); wr(5'h09, 16'hFFFF);
    wr(5'h0C, 16'hFFFF); wr(5'h0D, 16'hFFFF);
    chk(5'h10, "R8"); chk(5'h11, "R8"); chk(5'h12, "R8"); chk(5'h13, "R8");
    wr(5'h0B, 16'hFFFF); wr(5'h0D, 16'hFFFF);
    chk(5'h10, "R8_signed_ffff"); chk(5'h13, "R8_signed_ffff");

    // R7: operand-2 low word does not trigger
    wr(5'h0C, 16'h0002);
    chk(5'h10, "R7"); chk(5'h12, "R7"); chk(5'h0C, "R7");

    // R9: read-back of operand registers
    chk(5'h01, "R9"); chk(5'h02, "R9"); chk(5'h03, "R9");
    chk(5'h08, "R9"); chk(5'h0A, "R9"); chk(5'h0B, "R9"); chk(5'h0D, "R9");

    // R10: unmapped and read-only addresses
    wr(5'h1F, 16'hABCD); chk(5'h1F, "R10");
    wr(5'h06, 16'h5555); chk(5'h06, "R10"); chk(5'h04, "R10");
    wr(5'h10, 16'h9999); chk(5'h10, "R10");
    wr(5'h13, 16'h9999); chk(5'h13, "R10"); chk(5'h00, "R10");

    // random mix over every mode
    for (int i = 0; i < 150; i++) begin
      int kind;
      kind = int'($urandom % 4);
      if (kind < 3) begin
        if ($urandom % 4 == 0) begin
          wr(5'h04, rnd16()); wr(5'h05, rnd16());
        end
        wr(5'(kind), rnd16());
        wr(5'h03, rnd16());
        if ($urandom % 2 == 0) wr(5'h03, rnd16());
        chk(5'h04, kind == 0 ? "R2_rand" : kind == 1 ? "R3_rand" : "R4_rand");
        chk(5'h05, kind == 0 ? "R2_rand" : kind == 1 ? "R3_rand" : "R4_rand");
      end else begin
        bit s;
        s = 1'($urandom);
        wr(s ? 5'h0A : 5'h08, rnd16());
        wr(s ? 5'h0B : 5'h09, rnd16());
        wr(5'h0C, rnd16());
        wr(5'h0D, rnd16());
        chk(5'h10, "R8_rand"); chk(5'h11, "R8_rand");
        chk(5'h12, "R8_rand"); chk(5'h13, "R8_rand");
      end
    end

    repeat (2) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule